// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block drives the command protocol of a NOR flash that uses the common command-user-interface convention. A client asks for one of two operations: program a single 16-bit word, or erase the block that holds a given address. The sequencer then acts as a synchronous bus master toward the flash. It issues the command writes, polls the status word until the device reports ready, and always leaves the device in read-array mode. Each bus access lasts one clock. A write is a cycle with `fl_cs` and `fl_we` high. A read is a cycle with `fl_cs` high and `fl_we` low, and the sequencer samples `fl_rdata` on the clock edge that ends that cycle.

An erase takes a long time. While one is being polled, the sequencer watches `irq_req`. When `irq_req` is seen, it suspends the erase, puts the flash back in read-array mode and lowers `irq_mask` so that the rest of the system can run and use the flash. When `win_grant` arrives, it resumes the erase. A program request is first compared against the word already stored. A request that would need any bit to go from 0 to 1 is refused without touching the device.

Top module: `flash_cmd_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `err`, `irq_mask` and `fl_cs` are all 0.
- R2: A request is taken only when `req_valid` is high while `busy` is low. `req_op` 0 means program and 1 means erase. A request offered while busy has no effect: every bus cycle of the running operation keeps its own address.
- R3: A program request first reads the target word. If any bit is 1 in the new data and 0 in the stored word, the sequencer makes no write, sets `err` and ends the request.
- R4: An accepted program request writes, all to the request address: 0x60 and 0xD0 (only when UNLOCK_EN is set), 0x50, 0x40, then the data word. It then reads status until bit 7 (ready) is 1, and finally writes 0xFF.
- R5: An erase request writes 0x60 and 0xD0 (only when UNLOCK_EN is set), 0x50, 0x20, 0xD0 and 0x70. It then reads status until bit 7 is 1, and finishes with 0xFF.
- R6: If `irq_req` is high when an erase status read returns bit 7 = 0, the sequencer writes 0xB0 and 0x70, then reads status until bit 7 is 1. If bit 6 (suspended) is 1, it writes 0xFF and opens the window. When the window closes, it writes 0xD0 and then 0x70, and returns to polling.
- R7: If the status read that ends a suspend shows bit 6 = 0, the erase has already finished. The sequencer writes 0xFF and completes, with no resume command.
- R8: `irq_mask` is 1 for every busy cycle except those of the window, and 0 while idle.
- R9: During the window the sequencer makes no bus cycle. The window stays open until `win_grant` is sampled high.
- R10: A single erase may be suspended and resumed any number of times. Each suspend adds the same five-write group to the bus sequence.
- R11: `done` is high for exactly one cycle per accepted request. `err` is valid from that cycle and is held until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_op | input | 1 | 0 program word, 1 erase block |
| req_addr | input | AW | Word address or any address in the block |
| req_data | input | DW | Data to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last program was refused |
| irq_req | input | 1 | Interrupt wants service during an erase |
| win_grant | input | 1 | Closes the suspend window |
| irq_mask | output | 1 | Interrupts held off |
| fl_cs | output | 1 | Flash bus cycle |
| fl_we | output | 1 | Cycle is a write |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Command or data word |
| fl_rdata | input | DW | Array or status word read back |

## Verification
The bench runs a behavioural flash that logs every write. It compares the whole command sequence and its addresses against what the requirements predict. That catches a sequencer that drops the unlock pair, leaves out the status read after resume, or forgets the final 0xFF.

Bit-set programs must come back refused with an empty write log. A faulty blank check would either corrupt the word or refuse a legal program.

The erase corner cases cover:
- a suspend during which the device finishes the erase, which a wrong design would follow with a stray resume;
- two suspends in one erase, which a design that allows only one would miss;
- the exact width of the mask-low window, which would come out too short if the window ignored the grant.

A request offered mid-erase must leave the erase address untouched.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CHK_RD,
        ST_UNLK_A,
        ST_UNLK_B,
        ST_CLR,
        ST_PG_SETUP,
        ST_PG_DATA,
        ST_PG_POLL,
        ST_ER_SETUP,
        ST_ER_CONF,
        ST_ER_STAT,
        ST_ER_POLL,
        ST_SP_CMD,
        ST_SP_STAT,
        ST_SP_POLL,
        ST_SP_ARRAY,
        ST_SP_WAIT,
        ST_RS_CMD,
        ST_RS_STAT,
        ST_FINISH,
        ST_DONE
    } seq_state_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } seq_op_e;

    typedef enum logic [1:0] {
        BUS_NONE,
        BUS_READ,
        BUS_CMD,
        BUS_DATA
    } bus_kind_e;

    typedef struct packed {
        bus_kind_e  kind;
        logic [7:0] cmd;
    } bus_step_t;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_LOCKCFG = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_WORD    = 8'h40;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;

    localparam int READY_BIT = 7;
    localparam int SUSP_BIT  = 6;

    // Bus action that belongs to each sequencer state.
    function automatic bus_step_t step_of(seq_state_e s);
        bus_step_t r;
        r = '{kind: BUS_NONE, cmd: 8'h00};
        case (s)
            ST_CHK_RD, ST_PG_POLL, ST_ER_POLL, ST_SP_POLL: r.kind = BUS_READ;
            ST_PG_DATA:  r.kind = BUS_DATA;
            ST_UNLK_A:   r = '{kind: BUS_CMD, cmd: CMD_LOCKCFG};
            ST_UNLK_B:   r = '{kind: BUS_CMD, cmd: CMD_CONFIRM};
            ST_CLR:      r = '{kind: BUS_CMD, cmd: CMD_CLEAR};
            ST_PG_SETUP: r = '{kind: BUS_CMD, cmd: CMD_WORD};
            ST_ER_SETUP: r = '{kind: BUS_CMD, cmd: CMD_ERASE};
            ST_ER_CONF:  r = '{kind: BUS_CMD, cmd: CMD_CONFIRM};
            ST_ER_STAT:  r = '{kind: BUS_CMD, cmd: CMD_STATUS};
            ST_SP_CMD:   r = '{kind: BUS_CMD, cmd: CMD_SUSPEND};
            ST_SP_STAT:  r = '{kind: BUS_CMD, cmd: CMD_STATUS};
            ST_SP_ARRAY: r = '{kind: BUS_CMD, cmd: CMD_ARRAY};
            ST_RS_CMD:   r = '{kind: BUS_CMD, cmd: CMD_CONFIRM};
            ST_RS_STAT:  r = '{kind: BUS_CMD, cmd: CMD_STATUS};
            ST_FINISH:   r = '{kind: BUS_CMD, cmd: CMD_ARRAY};
            default:     r = '{kind: BUS_NONE, cmd: 8'h00};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter bit UNLOCK_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [DW-1:0] fl_rdata,
    input  logic          irq_req,
    input  logic          win_grant,
    output seq_state_e    state,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic          busy,
    output logic          done,
    output logic          err
);

    seq_state_e nxt;
    seq_state_e first_cmd;
    seq_op_e    op_q;
    logic       err_q;
    logic       accept;
    logic       sets_bits;
    logic       st_ready;
    logic       st_susp;

    generate
        if (UNLOCK_EN) begin : g_unlock
            assign first_cmd = ST_UNLK_A;
        end else begin : g_no_unlock
            assign first_cmd = ST_CLR;
        end
    endgenerate

    assign accept    = (state == ST_IDLE) && req_valid;
    assign sets_bits = |(~fl_rdata & data_q);
    assign st_ready  = fl_rdata[READY_BIT];
    assign st_susp   = fl_rdata[SUSP_BIT];

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:     if (req_valid) nxt = req_op ? first_cmd : ST_CHK_RD;
            ST_CHK_RD:   nxt = sets_bits ? ST_DONE : first_cmd;
            ST_UNLK_A:   nxt = ST_UNLK_B;
            ST_UNLK_B:   nxt = ST_CLR;
            ST_CLR:      nxt = (op_q == OP_ERASE) ? ST_ER_SETUP : ST_PG_SETUP;
            ST_PG_SETUP: nxt = ST_PG_DATA;
            ST_PG_DATA:  nxt = ST_PG_POLL;
            ST_PG_POLL:  if (st_ready) nxt = ST_FINISH;
            ST_ER_SETUP: nxt = ST_ER_CONF;
            ST_ER_CONF:  nxt = ST_ER_STAT;
            ST_ER_STAT:  nxt = ST_ER_POLL;
            ST_ER_POLL: begin
                if (st_ready)     nxt = ST_FINISH;
                else if (irq_req) nxt = ST_SP_CMD;
            end
            ST_SP_CMD:   nxt = ST_SP_STAT;
            ST_SP_STAT:  nxt = ST_SP_POLL;
            ST_SP_POLL:  if (st_ready) nxt = st_susp ? ST_SP_ARRAY : ST_FINISH;
            ST_SP_ARRAY: nxt = ST_SP_WAIT;
            ST_SP_WAIT:  if (win_grant) nxt = ST_RS_CMD;
            ST_RS_CMD:   nxt = ST_RS_STAT;
            ST_RS_STAT:  nxt = ST_ER_POLL;
            ST_FINISH:   nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= OP_PROGRAM;
            addr_q <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                op_q   <= seq_op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
                err_q  <= 1'b0;
            end else if (state == ST_CHK_RD && sets_bits) begin
                err_q <= 1'b1;
            end
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);
    assign err  = err_q;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> ($stable(addr_q) && $stable(data_q) && $stable(op_q)));

    // R3
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> ($past(state) == ST_CHK_RD));

    // R9
    resume_after_window_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RS_CMD) |-> ($past(state) == ST_SP_WAIT && $past(win_grant)));

endmodule

// File: rtl/flash_seq_busdrv.sv
module flash_seq_busdrv
    import flash_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_state_e    state,
    input  logic          busy,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] data_q,
    output logic          fl_cs,
    output logic          fl_we,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic          irq_mask
);

    localparam int PAD = DW - 8;

    bus_step_t step;

    assign step     = step_of(state);
    assign fl_cs    = (step.kind != BUS_NONE);
    assign fl_we    = (step.kind == BUS_CMD) || (step.kind == BUS_DATA);
    assign fl_addr  = addr_q;
    assign fl_wdata = (step.kind == BUS_DATA) ? data_q
                    : (step.kind == BUS_CMD)  ? {{PAD{1'b0}}, step.cmd}
                    : '0;
    assign irq_mask = busy && (state != ST_SP_WAIT);

    // R9
    quiet_window_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !irq_mask) |-> !fl_cs);

    // R6
    resume_status_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_SP_WAIT && fl_cs && fl_we) |=>
            (fl_cs && fl_we && fl_wdata[7:0] == CMD_STATUS));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter bit UNLOCK_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          done,
    output logic          err,
    input  logic          irq_req,
    input  logic          win_grant,
    output logic          irq_mask,
    output logic          fl_cs,
    output logic          fl_we,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata
);

    seq_state_e    state;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    flash_seq_ctrl #(.AW(AW), .DW(DW), .UNLOCK_EN(UNLOCK_EN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .fl_rdata  (fl_rdata),
        .irq_req   (irq_req),
        .win_grant (win_grant),
        .state     (state),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    flash_seq_busdrv #(.AW(AW), .DW(DW)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .busy     (busy),
        .addr_q   (addr_q),
        .data_q   (data_q),
        .fl_cs    (fl_cs),
        .fl_we    (fl_we),
        .fl_addr  (fl_addr),
        .fl_wdata (fl_wdata),
        .irq_mask (irq_mask)
    );

    // R4
    array_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> $past(fl_cs && fl_we && fl_wdata[7:0] == CMD_ARRAY));

endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int ERASE_LEN = 20;
    localparam int PROG_LEN = 3;

    typedef struct packed {
        logic        op;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [15:0] preset;
        logic        exp_err;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 4'd5, 16'h1234, 16'hFFFF, 1'b0},
        '{1'b0, 4'd6, 16'h00F0, 16'h0FF0, 1'b0},
        '{1'b0, 4'd7, 16'h8001, 16'h7FFF, 1'b1},
        '{1'b0, 4'd2, 16'h0000, 16'hA5A5, 1'b0},
        '{1'b0, 4'd9, 16'hFFFF, 16'hFFFE, 1'b1},
        '{1'b1, 4'd4, 16'h0000, 16'h0000, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_op = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic busy, done, err, irq_mask, fl_cs, fl_we;
    logic irq_req;
    logic win_grant;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata, fl_rdata;

    always #2.5 clk = ~clk;

    flash_cmd_seq #(.AW(AW), .DW(DW), .UNLOCK_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .err(err), .irq_req(irq_req), .win_grant(win_grant), .irq_mask(irq_mask),
        .fl_cs(fl_cs), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata)
    );

    // ---------------- behavioural flash ----------------
    logic [15:0] mem [16];
    logic        st_mode;
    logic [1:0]  pend;
    int          prog_left;
    int          erase_left;
    logic        f_susp;
    logic [1:0]  eblk;
    logic        fin_on_susp = 1'b0;
    logic        load_en = 1'b0;
    logic [3:0]  load_a = '0;
    logic [15:0] load_v = '0;
    logic        f_ready;

    assign f_ready  = (prog_left == 0) && (erase_left == 0 || f_susp);
    assign fl_rdata = st_mode ? {8'h00, f_ready, f_susp, 6'b0} : mem[fl_addr[3:0]];

    always @(posedge clk) begin
        if (rst) begin
            st_mode <= 1'b0; pend <= 2'd0; prog_left <= 0; erase_left <= 0;
            f_susp <= 1'b0; eblk <= 2'd0;
            for (int i = 0; i < 16; i++) mem[i] <= 16'hFFFF;
        end else begin
            if (load_en) mem[load_a] <= load_v;
            if (prog_left > 0) prog_left <= prog_left - 1;
            if (erase_left > 0 && !f_susp) begin
                if (erase_left == 1)
                    for (int i = 0; i < 16; i++) if (i[3:2] == eblk) mem[i] <= 16'hFFFF;
                erase_left <= erase_left - 1;
            end
            if (fl_cs && fl_we) begin
                if (pend == 2'd2) begin
                    mem[fl_addr[3:0]] <= mem[fl_addr[3:0]] & fl_wdata;
                    prog_left <= PROG_LEN; st_mode <= 1'b1; pend <= 2'd0;
                end else begin
                    case (fl_wdata[7:0])
                        8'hFF: begin st_mode <= 1'b0; pend <= 2'd0; end
                        8'h70: st_mode <= 1'b1;
                        8'h60: pend <= 2'd1;
                        8'h40: pend <= 2'd2;
                        8'h20: pend <= 2'd3;
                        8'hB0: begin
                            st_mode <= 1'b1;
                            if (erase_left > 0) begin
                                if (fin_on_susp) begin
                                    for (int i = 0; i < 16; i++) if (i[3:2] == eblk) mem[i] <= 16'hFFFF;
                                    erase_left <= 0;
                                end else f_susp <= 1'b1;
                            end
                        end
                        8'hD0: begin
                            if (pend == 2'd3) begin
                                erase_left <= ERASE_LEN; eblk <= fl_addr[3:2]; st_mode <= 1'b1;
                            end else if (pend != 2'd1 && f_susp) f_susp <= 1'b0;
                            pend <= 2'd0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // ---------------- interrupt source ----------------
    int irq_quota = 0;
    int irq_used;
    int win_cnt;
    int gap;

    assign irq_req = (irq_used < irq_quota) && (gap == 0);

    always @(posedge clk) begin
        if (rst) begin
            irq_used <= 0; win_cnt <= 0; gap <= 0; win_grant <= 1'b0;
        end else if (busy && !irq_mask) begin
            win_grant <= (win_cnt == 2);
            if (win_cnt == 2) begin irq_used <= irq_used + 1; gap <= 6; end
            win_cnt <= win_cnt + 1;
        end else begin
            win_cnt <= 0; win_grant <= 1'b0;
            if (gap > 0) gap <= gap - 1;
        end
    end

    // ---------------- monitor ----------------
    logic [15:0] log_d [1024];
    logic [AW-1:0] log_a [1024];
    int log_n = 0;
    int done_cnt = 0;
    int masklow_cnt = 0;
    int winbus_cnt = 0;
    int idlemask_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (fl_cs && fl_we) begin
                log_d[log_n % 1024] <= fl_wdata;
                log_a[log_n % 1024] <= fl_addr;
                log_n <= log_n + 1;
            end
            if (done) done_cnt <= done_cnt + 1;
            if (busy && !irq_mask) masklow_cnt <= masklow_cnt + 1;
            if (busy && !irq_mask && fl_cs) winbus_cnt <= winbus_cnt + 1;
            if (!busy && irq_mask) idlemask_cnt <= idlemask_cnt + 1;
        end
    end

    // ---------------- checking ----------------
    int checks = 0;
    int errors = 0;
    logic [15:0] exp_seq [32];
    int exp_n;
    int s_log, s_done, s_mask, s_wbus, s_idle;
    logic timed_out;

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [15:0] v);
        exp_seq[exp_n] = v;
        exp_n++;
    endtask

    task automatic exp_erase_head();
        push(16'h60); push(16'hD0); push(16'h50); push(16'h20); push(16'hD0); push(16'h70);
    endtask

    task automatic exp_suspend_group();
        push(16'hB0); push(16'h70); push(16'hFF); push(16'hD0); push(16'h70);
    endtask

    task automatic check_seq(input string tag, input logic [3:0] a);
        int n;
        int bad;
        n = log_n - s_log;
        bad = 0;
        if (n == exp_n)
            for (int i = 0; i < n; i++)
                if (log_d[(s_log + i) % 1024] !== exp_seq[i] ||
                    log_a[(s_log + i) % 1024] !== AW'(a)) bad++;
        check(n == exp_n && bad == 0, tag, n * 256 + bad, exp_n * 256);
    endtask

    task automatic snap();
        s_log = log_n; s_done = done_cnt; s_mask = masklow_cnt;
        s_wbus = winbus_cnt; s_idle = idlemask_cnt; exp_n = 0;
    endtask

    task automatic preload(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        load_en = 1'b1; load_a = a; load_v = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic issue(input logic op, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic seen_err);
        timed_out = 1'b1;
        seen_err = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin
                timed_out = 1'b0; seen_err = err; break;
            end
            @(negedge clk);
        end
        if (timed_out) check(1'b0, "R11 done timeout", 0, 1);
        @(negedge clk);
        @(negedge clk);
    endtask

    logic got_err;

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !err && !irq_mask && !fl_cs, "R1 reset outputs",
              {busy, done, err, irq_mask, fl_cs}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !irq_mask && !fl_cs, "R1 idle after reset",
              {busy, irq_mask, fl_cs}, 0);

        // vector table: programs and a plain erase
        foreach (VECS[k]) begin
            preload(VECS[k].addr, VECS[k].preset);
            snap();
            issue(VECS[k].op, VECS[k].addr, VECS[k].data);
            wait_done(got_err);
            check(got_err == VECS[k].exp_err, "R3 err flag", got_err, VECS[k].exp_err);
            check(done_cnt - s_done == 1, "R11 one done pulse", done_cnt - s_done, 1);
            check(masklow_cnt == s_mask && idlemask_cnt == s_idle, "R8 mask held",
                  masklow_cnt - s_mask + idlemask_cnt - s_idle, 0);
            if (VECS[k].op) begin
                exp_erase_head(); push(16'hFF);
                check_seq("R5 erase sequence", VECS[k].addr);
                check(mem[VECS[k].addr] == 16'hFFFF, "R5 block erased", mem[VECS[k].addr], 16'hFFFF);
            end else if (VECS[k].exp_err) begin
                check_seq("R3 no writes on refusal", VECS[k].addr);
                check(mem[VECS[k].addr] == VECS[k].preset, "R3 word untouched",
                      mem[VECS[k].addr], VECS[k].preset);
            end else begin
                push(16'h60); push(16'hD0); push(16'h50); push(16'h40);
                push(VECS[k].data); push(16'hFF);
                check_seq("R4 program sequence", VECS[k].addr);
                check(mem[VECS[k].addr] == VECS[k].data, "R4 word programmed",
                      mem[VECS[k].addr], VECS[k].data);
            end
        end

        // R11: err held after refusal until the next accepted request
        preload(4'd1, 16'h0000);
        issue(1'b0, 4'd1, 16'h0001);
        wait_done(got_err);
        repeat (3) @(negedge clk);
        check(err == 1'b1, "R11 err held while idle", err, 1);

        // R2: request offered mid-erase is ignored
        preload(4'd0, 16'h1234);
        snap();
        issue(1'b1, 4'd8, 16'h0000);
        check(err == 1'b0, "R11 err cleared on accept", err, 0);
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_addr = '0; req_data = 16'h0000;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        wait_done(got_err);
        exp_erase_head(); push(16'hFF);
        check_seq("R2 erase unaffected by busy request", 4'd8);
        check(mem[0] == 16'h1234, "R2 ignored request left word", mem[0], 16'h1234);
        check(done_cnt - s_done == 1, "R2 single done", done_cnt - s_done, 1);

        // R6: one suspend / resume
        preload(4'd12, 16'h0000);
        snap();
        irq_quota = irq_used + 1;
        issue(1'b1, 4'd12, 16'h0000);
        wait_done(got_err);
        exp_erase_head(); exp_suspend_group(); push(16'hFF);
        check_seq("R6 suspend resume sequence", 4'd12);
        check(masklow_cnt - s_mask == 4, "R9 window length", masklow_cnt - s_mask, 4);
        check(winbus_cnt == s_wbus, "R9 bus quiet in window", winbus_cnt - s_wbus, 0);
        check(mem[12] == 16'hFFFF, "R6 erase completes", mem[12], 16'hFFFF);
        check(idlemask_cnt == s_idle, "R8 mask low while idle", idlemask_cnt - s_idle, 0);

        // R10: two suspends in one erase
        preload(4'd13, 16'h00FF);
        snap();
        irq_quota = irq_used + 2;
        issue(1'b1, 4'd13, 16'h0000);
        wait_done(got_err);
        exp_erase_head(); exp_suspend_group(); exp_suspend_group(); push(16'hFF);
        check_seq("R10 two suspend groups", 4'd13);
        check(masklow_cnt - s_mask == 8, "R10 two windows", masklow_cnt - s_mask, 8);
        check(mem[13] == 16'hFFFF, "R10 erase completes", mem[13], 16'hFFFF);

        // R7: erase finishes while suspending -> no resume
        preload(4'd3, 16'h0000);
        snap();
        fin_on_susp = 1'b1;
        irq_quota = irq_used + 1;
        issue(1'b1, 4'd3, 16'h0000);
        wait_done(got_err);
        irq_quota = irq_used;
        fin_on_susp = 1'b0;
        exp_erase_head(); push(16'hB0); push(16'h70); push(16'hFF);
        check_seq("R7 no resume after finished erase", 4'd3);
        check(masklow_cnt == s_mask, "R7 no window opened", masklow_cnt - s_mask, 0);
        check(mem[3] == 16'hFFFF, "R7 block erased", mem[3], 16'hFFFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule